// File: doc/BRIEF.md
# MSI Vector to Core Distributor

This block sits on the root-complex side of a PCIe link and turns inbound message-signalled interrupts into per-core interrupt events. Each inbound MSI lands as a write of a vector number into the trigger port. The vector is assigned to a core by its number modulo the core count. With the defaults of 32 vectors and 8 cores, core k owns vectors k, k+8, k+16 and k+24.

All vectors that belong to one core drive a single shared event line. Software in the interrupt handler reads that core's status register to find which of its vectors fired. It then clears those bits by writing ones to them. A per-vector enable mask, changed through separate set and clear registers, gates which status bits can raise the event. A parameter selects how the event is presented: either as a level or as a one-cycle pulse for each newly set, enabled bit.

Top module: `msi_core_fanout`

## Requirements
- R1: A trigger write of value v with v < 32 sets status bit v/8 of core v%8 at the next clock edge. Bit j of core k therefore stands for vector k+8*j.
- R2: A trigger write whose value is 32 or more, including values whose low 5 bits alone would be in range, changes no status bit.
- R3: Writing the status register of a core clears each bit written as 1. Bits written as 0 keep their value.
- R4: When a trigger sets a status bit in the same cycle that a status write clears it, the bit ends up set.
- R5: A write to the enable-set register sets the mask bits written as 1. A write to the enable-clear register clears the mask bits written as 1. A read of either register returns the current mask.
- R6: In level mode (PULSE_MODE=0), a core's event is high exactly while (status AND mask) is nonzero. It rises in the cycle after the trigger edge.
- R7: Two trigger writes of different vectors owned by the same core (for example 0 then 8) set two distinct status bits and share the one event line.
- R8: In pulse mode (PULSE_MODE=1), the event is high for one cycle after an edge at which an enabled bit was newly set. A re-trigger of a bit already set, or a trigger of a masked bit, gives no pulse.
- R9: While rst_ni is low and after its release, all status bits and mask bits read 0 and every event output is 0.
- R10: reg_sel_i selects the register: 0 status, 1 enable-set, 2 enable-clear, 3 reserved. The reserved register reads as 0 and ignores writes. reg_core_i picks the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_we_i | input | 1 | Trigger write strobe |
| trig_data_i | input | 32 | Vector number being triggered |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 status, 1 enable-set, 2 enable-clear, 3 reserved) |
| reg_core_i | input | 3 | Core index of the register access |
| reg_wdata_i | input | 4 | Register write data, one bit per owned vector |
| reg_rdata_o | output | 4 | Register read data for the selected core and register |
| event_o | output | 8 | Interrupt event, one line per core |

## Verification
A trigger write and a write-one-to-clear status access can fall in the same cycle on the same status bit. The bench provokes this by raising the trigger strobe and the register strobe on one edge. In the first case it clears the very bit being triggered. In the second case it clears a different bit of the same core. It then judges the result from the status read: the triggered bit must survive, and the unrelated bit must be gone. The pulse-mode instance runs on the same stimulus. Its pulses are checked against the newly-set rule when a bit is re-triggered and when a bit is masked.

// File: rtl/msi_fanout_pkg.sv
package msi_fanout_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_EN_SET = 2'd1,
    SEL_EN_CLR = 2'd2,
    SEL_RSVD   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/msi_trig_decode.sv
module msi_trig_decode #(
  parameter int NUM_VEC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [NUM_VEC-1:0] set_o
);
  localparam int VEC_W = $clog2(NUM_VEC);

  logic in_range;
  assign in_range = (data_i < DATA_W'(NUM_VEC));

  always_comb begin
    set_o = '0;
    if (we_i && in_range) set_o[data_i[VEC_W-1:0]] = 1'b1;
  end

  p_single_vec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_o));
  p_out_of_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && data_i >= DATA_W'(NUM_VEC)) |-> (set_o == '0));
endmodule

// File: rtl/msi_core_slice.sv
module msi_core_slice #(
  parameter int VPC        = 4,
  parameter bit PULSE_MODE = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [VPC-1:0] set_i,
  input  logic           stat_clr_we_i,
  input  logic           en_set_we_i,
  input  logic           en_clr_we_i,
  input  logic [VPC-1:0] wdata_i,
  output logic [VPC-1:0] status_o,
  output logic [VPC-1:0] mask_o,
  output logic           event_o
);
  logic [VPC-1:0] status_q, mask_q, clr_bits, kept;

  assign clr_bits = stat_clr_we_i ? wdata_i : '0;
  assign kept     = status_q & ~clr_bits;

  // set dominates clear so a concurrent inbound vector is never dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= kept | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mask_q <= '0;
    else if (en_set_we_i) mask_q <= mask_q | wdata_i;
    else if (en_clr_we_i) mask_q <= mask_q & ~wdata_i;
  end

  generate
    if (PULSE_MODE) begin : g_pulse
      logic pulse_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pulse_q <= 1'b0;
        else         pulse_q <= |(set_i & ~kept & mask_q);
      end
      assign event_o = pulse_q;

      p_pulse_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_o |-> $past(|set_i));
    end else begin : g_level
      assign event_o = |(status_q & mask_q);

      p_level_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(set_i & mask_q) && !en_clr_we_i) |=> event_o);
    end
  endgenerate

  assign status_o = status_q;
  assign mask_o   = mask_q;

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_we_i |=> ((status_q & $past(wdata_i & ~set_i)) == '0));
  p_w0_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_we_i |=> ((status_q & $past(~wdata_i & status_q)) == $past(~wdata_i & status_q)));
endmodule

// File: rtl/msi_core_fanout.sv
module msi_core_fanout
  import msi_fanout_pkg::*;
#(
  parameter int NUM_VEC    = 32,
  parameter int NUM_CORES  = 8,
  parameter int DATA_W     = 32,
  parameter bit PULSE_MODE = 1'b0,
  localparam int VPC       = NUM_VEC / NUM_CORES,
  localparam int CORE_W    = $clog2(NUM_CORES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 trig_we_i,
  input  logic [DATA_W-1:0]    trig_data_i,
  input  logic                 reg_we_i,
  input  logic [1:0]           reg_sel_i,
  input  logic [CORE_W-1:0]    reg_core_i,
  input  logic [VPC-1:0]       reg_wdata_i,
  output logic [VPC-1:0]       reg_rdata_o,
  output logic [NUM_CORES-1:0] event_o
);
  reg_sel_e       sel;
  logic [NUM_VEC-1:0] set_vec;
  logic [VPC-1:0] status_w [NUM_CORES];
  logic [VPC-1:0] mask_w   [NUM_CORES];

  assign sel = reg_sel_e'(reg_sel_i);

  msi_trig_decode #(.NUM_VEC(NUM_VEC), .DATA_W(DATA_W)) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (trig_we_i),
    .data_i (trig_data_i),
    .set_o  (set_vec)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    logic [VPC-1:0] core_set;
    logic           hit;
    for (genvar j = 0; j < VPC; j++) begin : g_bit
      assign core_set[j] = set_vec[k + NUM_CORES*j];  // interleaved ownership
    end
    assign hit = reg_we_i && (reg_core_i == CORE_W'(k));

    msi_core_slice #(.VPC(VPC), .PULSE_MODE(PULSE_MODE)) u_slice (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .set_i         (core_set),
      .stat_clr_we_i (hit && sel == SEL_STATUS),
      .en_set_we_i   (hit && sel == SEL_EN_SET),
      .en_clr_we_i   (hit && sel == SEL_EN_CLR),
      .wdata_i       (reg_wdata_i),
      .status_o      (status_w[k]),
      .mask_o        (mask_w[k]),
      .event_o       (event_o[k])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_STATUS:             reg_rdata_o = status_w[reg_core_i];
      SEL_EN_SET, SEL_EN_CLR: reg_rdata_o = mask_w[reg_core_i];
      default:                reg_rdata_o = '0;
    endcase
  end

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> (event_o == '0));
  p_rsvd_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_RSVD) |-> (reg_rdata_o == '0));
  p_ignore_big_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_we_i && trig_data_i >= DATA_W'(NUM_VEC) && !reg_we_i) |=> $stable(set_vec) || $past(set_vec) == '0);
endmodule

// File: tb/msi_core_fanout_tb.sv
module msi_core_fanout_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_we = 1'b0;
  logic [31:0] trig_data = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [2:0]  reg_core = '0;
  logic [3:0]  reg_wdata = '0;
  logic [3:0]  rdata, rdata_p;
  logic [7:0]  ev, ev_p;
  int total = 0;
  int bad = 0;
  logic [3:0] rv;

  always #10 clk = ~clk;

  msi_core_fanout u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_we_i(trig_we), .trig_data_i(trig_data),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_core_i(reg_core),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .event_o(ev));

  msi_core_fanout #(.PULSE_MODE(1'b1)) u_dut_pulse (
    .clk_i(clk), .rst_ni(rst_n), .trig_we_i(trig_we), .trig_data_i(trig_data),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_core_i(reg_core),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata_p), .event_o(ev_p));

  localparam int NT = 8;
  localparam logic [31:0] T_VAL  [NT] = '{32'd0, 32'd8, 32'd13, 32'd31, 32'd32, 32'h45, 32'd26, 32'd24};
  localparam logic [2:0]  T_CORE [NT] = '{3'd0, 3'd0, 3'd5, 3'd7, 3'd0, 3'd5, 3'd2, 3'd0};
  localparam logic [3:0]  T_STAT [NT] = '{4'b0001, 4'b0011, 4'b0010, 4'b1000, 4'b0011, 4'b0010, 4'b1000, 4'b1011};
  localparam logic [7:0]  T_EV   [NT] = '{8'h01, 8'h01, 8'h21, 8'hA1, 8'hA1, 8'hA1, 8'hA5, 8'hA5};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic trig(input logic [31:0] v);
    @(negedge clk); trig_we = 1'b1; trig_data = v;
    @(negedge clk); trig_we = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [2:0] c, input logic [3:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_core = c; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [2:0] c, output logic [3:0] d);
    reg_sel = s; reg_core = c; #1; d = rdata;
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    rd(2'd0, 3'd0, rv); chk("R9 status", rv, 4'h0);
    chk("R9 event", ev, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, 3'd3, rv); chk("R9 mask", rv, 4'h0);
    chk("R9 event after release", ev, 8'h00);

    for (int c = 0; c < 8; c++) wr(2'd1, 3'(c), 4'hF);
    rd(2'd1, 3'd6, rv); chk("R5 enable set", rv, 4'hF);

    // R1 R2 R6 R7: table walk
    for (int i = 0; i < NT; i++) begin
      trig(T_VAL[i]);
      rd(2'd0, T_CORE[i], rv);
      chk($sformatf("R1/R2/R7 status step %0d", i), rv, T_STAT[i]);
      chk($sformatf("R6 event step %0d", i), ev, T_EV[i]);
    end

    // R3: write-one clear, zeros keep
    wr(2'd0, 3'd0, 4'b0011);
    rd(2'd0, 3'd0, rv); chk("R3 partial clear", rv, 4'b1000);
    chk("R6 event stays", ev[0], 1'b1);
    wr(2'd0, 3'd0, 4'b1000);
    chk("R6 event drops", ev[0], 1'b0);
    wr(2'd0, 3'd7, 4'b0000);
    rd(2'd0, 3'd7, rv); chk("R3 zero write keeps", rv, 4'b1000);

    // R4: concurrent trigger and clear
    trig(32'd2);
    rd(2'd0, 3'd2, rv); chk("R4 prep", rv, 4'b1001);
    @(negedge clk); trig_we = 1'b1; trig_data = 32'd2;
    reg_we = 1'b1; reg_sel = 2'd0; reg_core = 3'd2; reg_wdata = 4'b0001;
    @(negedge clk); trig_we = 1'b0; reg_we = 1'b0;
    rd(2'd0, 3'd2, rv); chk("R4 set wins same bit", rv, 4'b1001);
    @(negedge clk); trig_we = 1'b1; trig_data = 32'd2;
    reg_we = 1'b1; reg_sel = 2'd0; reg_core = 3'd2; reg_wdata = 4'b1000;
    @(negedge clk); trig_we = 1'b0; reg_we = 1'b0;
    rd(2'd0, 3'd2, rv); chk("R4 other bit cleared", rv, 4'b0001);

    // R5: enable clear gates event
    wr(2'd2, 3'd5, 4'b0010);
    rd(2'd1, 3'd5, rv); chk("R5 mask via set reg", rv, 4'b1101);
    rd(2'd2, 3'd5, rv); chk("R5 mask via clr reg", rv, 4'b1101);
    chk("R5 masked event", ev[5], 1'b0);
    rd(2'd0, 3'd5, rv); chk("R5 status kept", rv, 4'b0010);

    // R10: reserved register
    wr(2'd3, 3'd5, 4'hF);
    rd(2'd3, 3'd5, rv); chk("R10 rsvd reads 0", rv, 4'h0);
    rd(2'd1, 3'd5, rv); chk("R10 rsvd write ignored", rv, 4'b1101);
    rd(2'd0, 3'd5, rv); chk("R10 rsvd no status clear", rv, 4'b0010);

    // R8: pulse mode instance
    wr(2'd0, 3'd1, 4'hF);
    wr(2'd2, 3'd1, 4'b0010);
    chk("R8 idle", ev_p[1], 1'b0);
    trig(32'd1);
    chk("R8 pulse high", ev_p[1], 1'b1);
    @(negedge clk);
    chk("R8 pulse one cycle", ev_p[1], 1'b0);
    trig(32'd1);
    chk("R8 retrigger no pulse", ev_p[1], 1'b0);
    trig(32'd9);
    chk("R8 masked no pulse", ev_p[1], 1'b0);
    rd(2'd0, 3'd1, rv); chk("R8 status set", rv, 4'b0011);
    chk("R6 level instance high", ev[1], 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule